// File: doc/BRIEF.md
# Floating-Point Multiply Special-Case Resolver

This block screens a pair of IEEE 754 double-precision operands at the front of a multiplier, before any mantissa work is done. It sorts each operand into zero, finite non-zero, infinity, quiet NaN or signalling NaN. From the pair it decides whether the product is already known. If it is, the block gives the finished 64-bit word at once with any invalid-operation flag. If the invalid trap is enabled and the case is invalid, it raises a trap request and writes no result. If neither holds, it tells the downstream stages to carry on with the real multiply.

NaN operands are resolved in a fixed priority order. The first operand is looked at before the second. A signalling NaN is turned into a quiet NaN by setting its quiet bit, so its payload and sign are kept. The default NaN is used only when infinity is multiplied by zero. The stage is purely combinational, so all outputs follow the operands within the same cycle. Normalising subnormals, the mantissa product and rounding belong to later stages.

Top module: `fpm_special_resolve`

## Requirements
- R1: For every infinity or zero result, bit 63 (the sign) equals the XOR of the two operand sign bits (bit 63 of each operand).
- R2: Infinity times zero, in either operand order and with the trap disabled, returns the default quiet NaN 0x7FF8000000000000 and sets the invalid flag.
- R3: When an invalid case occurs and the trap enable is 1, the trap request is 1 and the bypass-valid, invalid flag and go-on outputs are all 0. The trap enable has no effect on the outputs of any case that is not invalid.
- R4: Infinity times a finite non-zero value (normal or subnormal) returns an infinity with exponent bits 62:52 all ones, fraction 0 and the XOR sign, with no flag raised.
- R5: If operand A is a signalling NaN, the result is operand A with bit 51 forced to 1, and the invalid flag is set. This holds whatever operand B is. A NaN has exponent bits 62:52 all ones and a non-zero fraction in bits 51:0, and bit 51 equal to 0 marks it as signalling.
- R6: If operand A is a quiet NaN and operand B is a signalling NaN, the result is operand B with bit 51 set, and the invalid flag is set. If operand A is a quiet NaN and operand B is not a signalling NaN, the result is operand A unchanged, with no flag.
- R7: If only operand B is a NaN, the result is operand B with bit 51 set. The invalid flag is raised only if B was signalling.
- R8: A zero (exponent and fraction all zero) times a finite value returns a zero carrying the XOR sign, with no flag raised.
- R9: When both operands are finite and non-zero (normal or subnormal), the go-on output is 1, the bypass-valid output is 0 and no flag is raised.
- R10: For every operand pair, exactly one of bypass-valid, trap request and go-on is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 64 | First operand, IEEE 754 double (examined first for NaNs) |
| opB | input | 64 | Second operand, IEEE 754 double |
| trapInvalidEn | input | 1 | 1 = an invalid case requests a trap instead of giving a result |
| bypassValid | output | 1 | The product is fully known and is on bypassResult |
| bypassResult | output | 64 | Finished product word when bypassValid is 1, otherwise 0 |
| invalidFlag | output | 1 | Invalid-operation flag for the bypassed result |
| trapReq | output | 1 | Invalid trap requested; no result is written |
| mulGo | output | 1 | Both operands are finite non-zero; the full multiply must run |

## Verification
Every output is a combinational function of the current operands and trap enable, so each result is due in the same cycle as its stimulus, with no register on the path. The bench applies each operand pair on the falling clock edge and samples all five outputs a quarter period later, well before the next rising edge. It compares them against a model written from the requirements. Seeded random operand pairs drawn over the five operand classes are mixed with directed pairs for each priority corner, with the trap enable toggled for both.

// File: rtl/fpm_sc_pkg.sv
package fpm_sc_pkg;

  // classification of one operand
  typedef struct packed {
    logic isZero;
    logic isInf;
    logic isNan;
    logic isSnan;
  } opClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pickA;
    logic pickB;
    logic pickInf;
    logic pickZero;
    logic pickDefNan;
    logic makeQuiet;
  } ctrlStrobe_t;

endpackage

// File: rtl/fpm_sc_classify.sv
module fpm_sc_classify
  import fpm_sc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output opClass_t              cls
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expOnes;
  logic              expZero;
  logic              fracZero;

  assign expField  = op[W-2 -: EXP_W];
  assign fracField = op[FRAC_W-1:0];
  assign expOnes   = &expField;
  assign expZero   = ~|expField;
  assign fracZero  = ~|fracField;

  always_comb begin
    cls.isZero = expZero & fracZero;
    cls.isInf  = expOnes & fracZero;
    cls.isNan  = expOnes & ~fracZero;
    cls.isSnan = expOnes & ~fracZero & ~fracField[FRAC_W-1];
  end
endmodule

// File: rtl/fpm_sc_ctrl.sv
module fpm_sc_ctrl
  import fpm_sc_pkg::*;
(
  input  opClass_t    clsA,
  input  opClass_t    clsB,
  input  logic        trapInvalidEn,
  output ctrlStrobe_t strobe,
  output logic        valid,
  output logic        invalid,
  output logic        trap,
  output logic        go
);
  ctrlStrobe_t rawStrobe;
  logic        rawInvalid;
  logic        rawGo;

  // priority decision: A NaN, B NaN, inf*zero, inf, zero, go
  always_comb begin
    rawStrobe  = '0;
    rawInvalid = 1'b0;
    rawGo      = 1'b0;
    if (clsA.isNan) begin
      if (clsA.isSnan) begin
        rawInvalid          = 1'b1;
        rawStrobe.pickA     = 1'b1;
        rawStrobe.makeQuiet = 1'b1;
      end else if (clsB.isSnan) begin
        rawInvalid          = 1'b1;
        rawStrobe.pickB     = 1'b1;
        rawStrobe.makeQuiet = 1'b1;
      end else begin
        rawStrobe.pickA = 1'b1;
      end
    end else if (clsB.isNan) begin
      rawStrobe.pickB     = 1'b1;
      rawStrobe.makeQuiet = 1'b1;
      rawInvalid          = clsB.isSnan;
    end else if ((clsA.isInf & clsB.isZero) | (clsB.isInf & clsA.isZero)) begin
      rawInvalid           = 1'b1;
      rawStrobe.pickDefNan = 1'b1;
    end else if (clsA.isInf | clsB.isInf) begin
      rawStrobe.pickInf = 1'b1;
    end else if (clsA.isZero | clsB.isZero) begin
      rawStrobe.pickZero = 1'b1;
    end else begin
      rawGo = 1'b1;
    end
  end

  // trap suppresses result and flag
  always_comb begin
    trap    = rawInvalid & trapInvalidEn;
    invalid = rawInvalid & ~trapInvalidEn;
    go      = rawGo;
    valid   = ~rawGo & ~trap;
    strobe  = trap ? '0 : rawStrobe;
  end
endmodule

// File: rtl/fpm_sc_datapath.sv
module fpm_sc_datapath
  import fpm_sc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  ctrlStrobe_t           strobe,
  output logic [EXP_W+FRAC_W:0] result
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] QUIET_MASK = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] DEF_NAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic         prodSign;
  logic [W-1:0] nanSrc;
  logic [W-1:0] nanOut;

  assign prodSign = opA[W-1] ^ opB[W-1];
  assign nanSrc   = strobe.pickA ? opA : opB;
  assign nanOut   = strobe.makeQuiet ? (nanSrc | QUIET_MASK) : nanSrc;

  always_comb begin
    result = '0;
    if (strobe.pickA | strobe.pickB)
      result = nanOut;
    else if (strobe.pickDefNan)
      result = DEF_NAN;
    else if (strobe.pickInf)
      result = {prodSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (strobe.pickZero)
      result = {prodSign, {(W-1){1'b0}}};
  end
endmodule

// File: rtl/fpm_special_resolve.sv
module fpm_special_resolve
  import fpm_sc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic                  trapInvalidEn,
  output logic                  bypassValid,
  output logic [EXP_W+FRAC_W:0] bypassResult,
  output logic                  invalidFlag,
  output logic                  trapReq,
  output logic                  mulGo
);
  localparam int W = EXP_W + FRAC_W + 1;

  opClass_t    cls [2];
  ctrlStrobe_t strobe;
  logic [W-1:0] ops [2];

  assign ops[0] = opA;
  assign ops[1] = opB;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fpm_sc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
      .op  (ops[gi]),
      .cls (cls[gi])
    );
  end

  fpm_sc_ctrl ctrl_i (
    .clsA          (cls[0]),
    .clsB          (cls[1]),
    .trapInvalidEn (trapInvalidEn),
    .strobe        (strobe),
    .valid         (bypassValid),
    .invalid       (invalidFlag),
    .trap          (trapReq),
    .go            (mulGo)
  );

  fpm_sc_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) dp_i (
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (bypassResult)
  );
endmodule

// File: rtl/fpm_special_resolve_chk.sv
module fpm_special_resolve_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic [EXP_W+FRAC_W:0] opA,
  input logic [EXP_W+FRAC_W:0] opB,
  input logic                  trapInvalidEn,
  input logic                  bypassValid,
  input logic [EXP_W+FRAC_W:0] bypassResult,
  input logic                  invalidFlag,
  input logic                  trapReq,
  input logic                  mulGo
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic resIsNan;
  logic aSpecial;
  logic bSpecial;
  assign resIsNan = (&bypassResult[W-2 -: EXP_W]) & (|bypassResult[FRAC_W-1:0]);
  assign aSpecial = (&opA[W-2 -: EXP_W]) | ~|opA[W-2:0];
  assign bSpecial = (&opB[W-2 -: EXP_W]) | ~|opB[W-2:0];

  always_comb begin
    p_one_outcome_r10: assert ($onehot({bypassValid, trapReq, mulGo}))
      else $error("outcome not one-hot");
    p_trap_needs_enable_r3: assert (!trapReq || (trapInvalidEn && !invalidFlag && !bypassValid))
      else $error("trap request inconsistent");
    p_invalid_gives_qnan_r2: assert (!invalidFlag || (bypassValid && resIsNan && bypassResult[FRAC_W-1]))
      else $error("invalid result not a quiet NaN");
    p_sign_xor_r1: assert (!bypassValid || resIsNan || (bypassResult[W-1] == (opA[W-1] ^ opB[W-1])))
      else $error("result sign mismatch");
    p_go_finite_r9: assert (!mulGo || (!aSpecial && !bSpecial && !invalidFlag))
      else $error("go-on with special operand");
  end
endmodule

bind fpm_special_resolve fpm_special_resolve_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (.*);

// File: tb/fpm_special_resolve_tb_top.sv
module fpm_special_resolve_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        trapInvalidEn = 1'b0;
  logic        bypassValid;
  logic [63:0] bypassResult;
  logic        invalidFlag;
  logic        trapReq;
  logic        mulGo;

  int checks = 0;
  int failures = 0;

  localparam logic [63:0] QBIT   = 64'h0008_0000_0000_0000;
  localparam logic [63:0] DEFNAN = 64'h7FF8_0000_0000_0000;

  always #10 clk = ~clk;

  fpm_special_resolve dut_i (
    .opA, .opB, .trapInvalidEn, .bypassValid, .bypassResult,
    .invalidFlag, .trapReq, .mulGo
  );

  function automatic logic fNan(logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic logic fSnan(logic [63:0] x);
    return fNan(x) && !x[51];
  endfunction
  function automatic logic fInf(logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] == 0);
  endfunction
  function automatic logic fZero(logic [63:0] x);
    return x[62:0] == 0;
  endfunction

  // category: 0 zero, 1 subnormal, 2 normal, 3 inf, 4 qnan, 5 snan
  function automatic logic [63:0] mkOp(int cat, logic s);
    logic [51:0] fr;
    logic [10:0] ex;
    fr = {$urandom, $urandom};
    ex = 11'($urandom_range(1, 2046));
    case (cat)
      0: return {s, 63'd0};
      1: return {s, 11'd0, fr | 52'd1};
      2: return {s, ex, fr};
      3: return {s, 11'h7FF, 52'd0};
      4: return {s, 11'h7FF, 1'b1, fr[50:0]};
      default: return {s, 11'h7FF, 1'b0, fr[50:1], 1'b1};
    endcase
  endfunction

  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic te,
                       output logic [67:0] e, output string tag);
    logic v, inv, tr, g;
    logic [63:0] r;
    logic s;
    s = a[63] ^ b[63];
    v = 1; inv = 0; tr = 0; g = 0; r = '0;
    if (fNan(a)) begin
      if (fSnan(a)) begin r = a | QBIT; inv = 1; tag = "R5"; end
      else if (fSnan(b)) begin r = b | QBIT; inv = 1; tag = "R6"; end
      else begin r = a; tag = "R6"; end
    end else if (fNan(b)) begin
      r = b | QBIT; inv = fSnan(b); tag = "R7";
    end else if ((fInf(a) && fZero(b)) || (fInf(b) && fZero(a))) begin
      r = DEFNAN; inv = 1; tag = "R2";
    end else if (fInf(a) || fInf(b)) begin
      r = {s, 11'h7FF, 52'd0}; tag = "R4";
    end else if (fZero(a) || fZero(b)) begin
      r = {s, 63'd0}; tag = "R8";
    end else begin
      v = 0; g = 1; tag = "R9";
    end
    if (inv && te) begin
      v = 0; inv = 0; tr = 1; r = '0; tag = {tag, "/R3"};
    end
    e = {v, inv, tr, g, r};
  endtask

  task automatic applyCheck(input logic [63:0] a, input logic [63:0] b, input logic te);
    logic [67:0] exp, act;
    string tag;
    @(negedge clk);
    opA = a; opB = b; trapInvalidEn = te;
    #5;
    model(a, b, te, exp, tag);
    act = {bypassValid, invalidFlag, trapReq, mulGo, bypassResult};
    checks++;
    if ($onehot({bypassValid, trapReq, mulGo}) == 1'b0) begin
      failures++;
      $display("FAIL R10 a=%h b=%h act v/t/g=%b%b%b expected one-hot", a, b,
               bypassValid, trapReq, mulGo);
    end else if (act !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h te=%b act=%h expected=%h", tag, a, b, te, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // reset state: zero operands during reset -> +0 bypass (R8)
    repeat (2) @(posedge clk);
    applyCheck(64'd0, 64'd0, 1'b0);
    rstN = 1'b1;
    // directed corners
    applyCheck(64'h7FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0); // R2 R1-sign not used
    applyCheck(64'h0000_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b0); // R2 reverse order
    applyCheck(64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1); // R3 trap
    applyCheck(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b1); // R3 no effect, R9
    applyCheck(64'h7FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1'b0); // R4 R1 neg inf
    applyCheck(64'h8000_0000_0000_0001, 64'hFFF0_0000_0000_0000, 1'b0); // R4 subnormal
    applyCheck(64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0002, 1'b0); // R5 A sNaN first
    applyCheck(64'hFFF8_0000_0000_00AA, 64'h7FF0_0000_0000_0055, 1'b0); // R6 B sNaN
    applyCheck(64'hFFF8_0000_0000_00AA, 64'h7FF8_0000_0000_0055, 1'b0); // R6 A kept
    applyCheck(64'hFFF8_0000_0000_00AA, 64'h7FF0_0000_0000_0055, 1'b1); // R6 trap R3
    applyCheck(64'h0000_0000_0000_0000, 64'h7FF4_0000_0000_0000, 1'b0); // R7 sNaN B
    applyCheck(64'h7FF0_0000_0000_0000, 64'hFFF8_0000_0000_0003, 1'b0); // R7 qNaN B, A inf
    applyCheck(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0007, 1'b0); // R8 R1 neg zero
    applyCheck(64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b0); // R9 subnormals
    // seeded random mix over classes, trap toggled
    for (int i = 0; i < 2000; i++) begin
      logic [63:0] a, b;
      a = mkOp($urandom_range(0, 5), 1'($urandom));
      b = mkOp($urandom_range(0, 5), 1'($urandom));
      applyCheck(a, b, 1'($urandom));
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule